// File: doc/BRIEF.md
# LPC Power-Down Entry Sequencer

This block puts an LPC host's bus pins into a safe state when the host enters a low-power state or a global reset occurs, and brings them back afterwards. It drives the active-low power-down indication, the active-low bus reset, the frame strobe and the four address/data lines. The address/data lines come as a data value plus an output enable.

There are two ways in. A graceful low-power entry raises the power-down indication first. It then waits for a minimum gap before it asserts bus reset. The gap is counted in pulses of an external microsecond timebase, and the required count is a parameter. A global reset skips the gap and asserts power-down and bus reset in the same cycle. A global reset that arrives during the gap cuts the count short. On exit, bus reset is released first and power-down follows one timebase tick later. The pins then go back to their idle-high state.

All control and status pins are plain levels sampled on the clock. The block has no data stream, so it has no valid/ready handshake. Requests are single-cycle or level inputs. The block reacts only to a request that is meaningful in its current state.

Top module: `lpc_pwrdn_seq`

## Requirements
- R1: After reset the block is idle: `pd_n`=1, `bus_rst_n`=1, `frame_n`=1, `ad_oe`=1, `ad_out`=4'hF and `state_o`=2'b00.
- R2: An `lp_enter_req` sampled while idle moves the block to powering-down in the next cycle: `pd_n`=0, `bus_rst_n`=1 and `state_o`=2'b01.
- R3: In every state other than idle, `frame_n`=0 and `ad_out`=4'h0. `ad_oe` equals the parameter PARK_DRIVE_LOW (default 1, which means the lines are driven low; 0 means they float).
- R4: While powering down, bus reset asserts (`bus_rst_n`=0, `state_o`=2'b10) in the cycle after the (GAP_TICKS+1)-th `tick` sampled in that state (GAP_TICKS default 30). The first tick only sets the phase, so the gap lasts at least GAP_TICKS full tick periods. Bus reset is never low while `pd_n` is high.
- R5: A `gbl_rst_req` sampled while idle makes `pd_n` and `bus_rst_n` go low together in the next cycle, with `state_o`=2'b10.
- R6: A `gbl_rst_req` sampled while powering down moves the block to reset-held in the next cycle, whatever the gap count.
- R7: An `lp_exit_req` sampled in reset-held while `gbl_rst_req` is low moves the block to exiting in the next cycle: `bus_rst_n`=1, `pd_n`=0, `state_o`=2'b11.
- R8: In exiting, the first `tick` sampled returns the block to idle in the next cycle. `pd_n` therefore rises only after `bus_rst_n` has already been high, and frame and AD go back to the R1 values.
- R9: A `gbl_rst_req` sampled while exiting returns the block to reset-held (`bus_rst_n`=0) in the next cycle.
- R10: Requests with no meaning in the current state are ignored. This covers `lp_exit_req` in idle or powering-down, `lp_enter_req` outside idle, and `lp_exit_req` while `gbl_rst_req` is high.
- R11: `state_o` encodes 00 idle, 01 powering-down, 10 reset-held, 11 exiting. In idle, `pd_n`, `bus_rst_n` and `frame_n` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse, nominally once per microsecond |
| lp_enter_req | input | 1 | Request graceful low-power entry |
| lp_exit_req | input | 1 | Request exit from low power |
| gbl_rst_req | input | 1 | Global reset request (level) |
| pd_n | output | 1 | Power-down indication, active low |
| bus_rst_n | output | 1 | LPC bus reset, active low |
| frame_n | output | 1 | Frame strobe, active low |
| ad_oe | output | 1 | Output enable for the AD lines |
| ad_out | output | 4 | AD line drive value |
| state_o | output | 2 | Current sequencer state |

## Verification
The bench measures how many ticks the powering-down state sees before bus reset falls. A counter that is off by one would assert reset a tick early and shorten the guaranteed gap, and the count would expose it. The bench injects a global reset in the middle of the gap and again during exit. A design that let the count run on, or released power-down anyway, would show the wrong state in the next cycle. It also sends exit requests in idle, in powering-down, and while global reset is held, and sends an entry request in reset-held. A design that honoured any of these would leave the expected state early.

// File: rtl/lpc_pd_pkg.sv
package lpc_pd_pkg;
  localparam int unsigned AD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_PWRDN   = 2'b01,
    ST_RSTHELD = 2'b10,
    ST_EXIT    = 2'b11
  } pd_state_e;

  typedef struct packed {
    logic            pd_n;
    logic            rst_n;
    logic            frame_n;
    logic            ad_oe;
    logic [AD_W-1:0] ad_out;
  } pin_set_t;
endpackage

// File: rtl/lpc_pd_gap_cnt.sv
// Counts timebase ticks while the sequencer is powering down. It flags the
// tick that completes the gap: one phase-setting tick plus GAP_TICKS more.
module lpc_pd_gap_cnt #(
  parameter int unsigned GAP_TICKS = 30,
  localparam int unsigned CW = $clog2(GAP_TICKS + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LAST = CW'(GAP_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!run)                  cnt_q <= '0;
    else if (tick && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/lpc_pd_fsm.sv
module lpc_pd_fsm
  import lpc_pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      enter_req,
  input  logic      exit_req,
  input  logic      gbl_req,
  input  logic      gap_done,
  output pd_state_e state,
  output logic      gap_run
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (gbl_req) state_d = ST_RSTHELD;
                  else if (enter_req) state_d = ST_PWRDN;
      ST_PWRDN:   if (gbl_req || gap_done) state_d = ST_RSTHELD;
      ST_RSTHELD: if (!gbl_req && exit_req) state_d = ST_EXIT;
      ST_EXIT:    if (gbl_req) state_d = ST_RSTHELD;
                  else if (tick) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign gap_run = (state_q == ST_PWRDN);
endmodule

// File: rtl/lpc_pd_pinpark.sv
// Decodes the pin levels from the state. PARK_DRIVE_LOW chooses whether the
// AD lines are driven low or floated while the bus is parked.
module lpc_pd_pinpark
  import lpc_pd_pkg::*;
#(
  parameter bit PARK_DRIVE_LOW = 1'b1
) (
  input  pd_state_e state,
  output pin_set_t  pins
);
  logic parked;
  logic park_oe;
  assign parked = (state != ST_IDLE);

  generate
    if (PARK_DRIVE_LOW) begin : g_drive_low
      assign park_oe = 1'b1;
    end else begin : g_float
      assign park_oe = 1'b0;
    end
  endgenerate

  always_comb begin
    pins.pd_n    = !parked;
    pins.rst_n   = (state != ST_RSTHELD);
    pins.frame_n = !parked;
    pins.ad_oe   = parked ? park_oe : 1'b1;
    pins.ad_out  = parked ? '0 : '1;
  end
endmodule

// File: rtl/lpc_pwrdn_seq.sv
module lpc_pwrdn_seq
  import lpc_pd_pkg::*;
#(
  parameter int unsigned GAP_TICKS      = 30,
  parameter bit          PARK_DRIVE_LOW = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            lp_enter_req,
  input  logic            lp_exit_req,
  input  logic            gbl_rst_req,
  output logic            pd_n,
  output logic            bus_rst_n,
  output logic            frame_n,
  output logic            ad_oe,
  output logic [AD_W-1:0] ad_out,
  output logic [1:0]      state_o
);
  pd_state_e st;
  logic      gap_run, gap_done;
  pin_set_t  pins;

  lpc_pd_gap_cnt #(.GAP_TICKS(GAP_TICKS)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(gap_run), .tick(tick), .done(gap_done)
  );

  lpc_pd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enter_req(lp_enter_req),
    .exit_req(lp_exit_req), .gbl_req(gbl_rst_req), .gap_done(gap_done),
    .state(st), .gap_run(gap_run)
  );

  lpc_pd_pinpark #(.PARK_DRIVE_LOW(PARK_DRIVE_LOW)) u_pins (
    .state(st), .pins(pins)
  );

  assign pd_n      = pins.pd_n;
  assign bus_rst_n = pins.rst_n;
  assign frame_n   = pins.frame_n;
  assign ad_oe     = pins.ad_oe;
  assign ad_out    = pins.ad_out;
  assign state_o   = st;
endmodule

// File: rtl/lpc_pwrdn_seq_chk.sv
module lpc_pwrdn_seq_chk #(
  parameter int unsigned GAP_TICKS      = 30,
  parameter bit          PARK_DRIVE_LOW = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       gbl_rst_req,
  input logic       pd_n,
  input logic       bus_rst_n,
  input logic       frame_n,
  input logic       ad_oe,
  input logic [3:0] ad_out,
  input logic [1:0] state_o
);
  logic [15:0] seen_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                seen_ticks <= '0;
    else if (state_o != 2'b01)                 seen_ticks <= '0;
    else if (tick && seen_ticks != 16'hFFFF)   seen_ticks <= seen_ticks + 1'b1;
  end

  assert_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> (!frame_n && ad_out == 4'h0 && ad_oe == PARK_DRIVE_LOW));

  assert_rst_needs_pd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |-> !pd_n);

  assert_gap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 2'b01 && state_o == 2'b10 && !$past(gbl_rst_req))
      |-> (seen_ticks == 16'(GAP_TICKS + 1)));

  assert_gbl_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && gbl_rst_req) |=> (!pd_n && !bus_rst_n));

  assert_gbl_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 && gbl_rst_req) |=> (state_o == 2'b10));

  assert_exit_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_n) |-> (bus_rst_n && $past(bus_rst_n)));

  assert_gbl_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b11 && gbl_rst_req) |=> !bus_rst_n);

  assert_hold_under_gbl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && gbl_rst_req) |=> (state_o == 2'b10));

  assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00) |-> (pd_n && bus_rst_n && frame_n));
endmodule

bind lpc_pwrdn_seq lpc_pwrdn_seq_chk #(
  .GAP_TICKS(GAP_TICKS), .PARK_DRIVE_LOW(PARK_DRIVE_LOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .gbl_rst_req(gbl_rst_req),
  .pd_n(pd_n), .bus_rst_n(bus_rst_n), .frame_n(frame_n), .ad_oe(ad_oe),
  .ad_out(ad_out), .state_o(state_o)
);

// File: tb/tb_lpc_pwrdn_seq.sv
`timescale 1ns/1ps
module tb_lpc_pwrdn_seq;
  localparam int GAP = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic lp_enter_req = 1'b0, lp_exit_req = 1'b0, gbl_rst_req = 1'b0;
  logic pd_n, bus_rst_n, frame_n, ad_oe;
  logic [3:0] ad_out;
  logic [1:0] state_o;

  int total = 0, bad = 0, cycles = 0;
  int pd_ticks = 0, m_state = 0, m_cnt = 0, div = 0;
  bit tick_en = 1'b1, model_on = 1'b0;

  always #4 clk = ~clk;

  lpc_pwrdn_seq dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lp_enter_req(lp_enter_req),
    .lp_exit_req(lp_exit_req), .gbl_rst_req(gbl_rst_req), .pd_n(pd_n),
    .bus_rst_n(bus_rst_n), .frame_n(frame_n), .ad_oe(ad_oe),
    .ad_out(ad_out), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // timebase: one tick every fourth cycle, changed away from the rising edge
  always @(negedge clk) begin
    div = (div + 1) % 4;
    tick = tick_en && (div == 0);
  end

  // ticks sampled by the DUT while it reports powering-down
  always @(posedge clk) begin
    if (state_o == 2'b01) begin
      if (tick) pd_ticks++;
    end else if (state_o == 2'b00) pd_ticks = 0;
  end

  // behavioural reference: 0 idle, 1 powering down, 2 reset held, 3 exiting
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0;
    end else begin
      if (m_state == 0) begin
        if (gbl_rst_req) m_state = 2;
        else if (lp_enter_req) begin m_state = 1; m_cnt = 0; end
      end else if (m_state == 1) begin
        if (gbl_rst_req) m_state = 2;
        else if (tick) begin
          if (m_cnt == GAP) m_state = 2; else m_cnt++;
        end
      end else if (m_state == 2) begin
        if (!gbl_rst_req && lp_exit_req) m_state = 3;
      end else begin
        if (gbl_rst_req) m_state = 2;
        else if (tick) m_state = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      automatic int e_pins;
      automatic string tag;
      e_pins = (m_state == 0) ? {1'b1, 1'b1, 1'b1, 1'b1, 4'hF}
                              : {1'b0, (m_state != 2), 1'b0, 1'b1, 4'h0};
      tag = (m_state == 0) ? "R11 model" : (m_state == 1) ? "R2 model" :
            (m_state == 2) ? "R4 model" : "R7 model";
      chk(tag, {pd_n, bus_rst_n, frame_n, ad_oe, ad_out}, e_pins);
      chk("R11 state model", state_o, m_state);
    end
  end

  initial begin
    while (cycles < 50000) begin
      @(posedge clk);
      cycles++;
    end
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 50000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_state(input logic [1:0] s);
    for (int i = 0; i < 2000 && state_o != s; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    // R1 reset state
    chk("R1 pins", {pd_n, bus_rst_n, frame_n, ad_oe, ad_out}, 8'hFF);
    chk("R1 state", state_o, 0);
    // R10 exit while idle ignored
    lp_exit_req = 1; @(negedge clk); lp_exit_req = 0;
    chk("R10 exit in idle", state_o, 0);
    // R2 graceful entry
    lp_enter_req = 1; @(negedge clk); lp_enter_req = 0;
    chk("R2 pd_n", pd_n, 0);
    chk("R2 bus_rst_n", bus_rst_n, 1);
    chk("R3 frame_n", frame_n, 0);
    chk("R3 ad", {ad_oe, ad_out}, 5'h10);
    lp_exit_req = 1; @(negedge clk); lp_exit_req = 0;
    chk("R10 exit in powering-down", state_o, 1);
    wait_state(2'b10);
    chk("R4 ticks before reset", pd_ticks, GAP + 1);
    chk("R4 bus_rst_n", bus_rst_n, 0);
    // R10 entry in reset-held, exit under global reset
    lp_enter_req = 1; @(negedge clk); lp_enter_req = 0;
    chk("R10 enter in reset-held", state_o, 2);
    gbl_rst_req = 1; lp_exit_req = 1; @(negedge clk); lp_exit_req = 0;
    chk("R10 exit under global reset", state_o, 2);
    gbl_rst_req = 0; @(negedge clk);
    // R7 exit
    lp_exit_req = 1; @(negedge clk); lp_exit_req = 0;
    chk("R7 state", state_o, 3);
    chk("R7 pins", {pd_n, bus_rst_n}, 2'b01);
    wait_state(2'b00);
    chk("R8 idle pins", {pd_n, bus_rst_n, frame_n, ad_oe, ad_out}, 8'hFF);
    // R5 global reset from idle
    gbl_rst_req = 1; @(negedge clk); gbl_rst_req = 0;
    chk("R5 both low", {pd_n, bus_rst_n}, 2'b00);
    chk("R5 state", state_o, 2);
    // R9 global reset while exiting, ticks paused
    tick_en = 0; @(negedge clk);
    lp_exit_req = 1; @(negedge clk); lp_exit_req = 0;
    chk("R9 in exiting", state_o, 3);
    gbl_rst_req = 1; @(negedge clk); gbl_rst_req = 0;
    chk("R9 back to held", bus_rst_n, 0);
    tick_en = 1;
    lp_exit_req = 1; @(negedge clk); lp_exit_req = 0;
    wait_state(2'b00);
    // R6 global reset mid-gap
    lp_enter_req = 1; @(negedge clk); lp_enter_req = 0;
    repeat (20) @(negedge clk);
    gbl_rst_req = 1; @(negedge clk); gbl_rst_req = 0;
    chk("R6 state", state_o, 2);
    chk("R6 cut short", (pd_ticks < GAP + 1) ? 1 : 0, 1);
    lp_exit_req = 1; @(negedge clk); lp_exit_req = 0;
    wait_state(2'b00);
    chk("R11 final idle", state_o, 0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule